// File: doc/BRIEF.md
# Expansion-Bus I/O Register Window Slave

This block sits on the peripheral side of a simplified, ISA-style 8-bit I/O expansion bus. It watches the active-low read and write strobes, two active-low slot enables and ten address lines. It claims only those cycles whose upper address bits match a configured base, which opens a window of eight byte-wide registers. The register file itself lives outside the block. The block tells the register file which offset is being read or written and moves the byte across the shared data bus.

All bus inputs pass through two flip-flop stages into the local clock domain. A claimed read raises a one-clock read request with the offset. The register file answers with a byte in the same cycle. The block then drives that byte onto the tri-state data bus until the read strobe rises. The driver is switched off combinationally from the raw strobe, so release does not wait for a clock edge. A claimed write is reported as a single-beat output stream after the write strobe rises. That stream has a valid signal and no ready signal, because the bus cannot be stalled: the consumer must accept every beat in the cycle it appears. A pattern mode answers reads of offset 0 with a fixed test byte. This lets bring-up software confirm the decode without a register file attached.

Top module: `isa_slave_if`

## Requirements
- R1: A cycle hits only when bus_addr[9:3] equals bits 9:3 of the BASE_ADDR parameter (default 0x2F8). bus_addr[2:0] is the register offset.
- R2: A cycle is claimed only when slot_sel_n and slot_ioen_n are both low at the strobe's falling edge, in addition to the address hit.
- R3: During a claimed read, d_drive_o goes high within five clock edges of bus_ior_n falling. While it is high, bus_d carries the rd_data_i value that was presented in the rd_req_o cycle.
- R4: d_drive_o is low, and bus_d is not driven, at all times except during a claimed read strobe. d_drive_o drops with no clock edge as soon as bus_ior_n returns high.
- R5: Each claimed read produces exactly one rd_req_o pulse, one clock long, with rd_off_o equal to the offset. Missed cycles produce none.
- R6: Each claimed write produces exactly one wr_valid_o pulse, one clock long, after bus_iow_n rises. wr_off_o is the offset at the strobe's fall. wr_data_o is the last bus_d value seen while the strobe was still low.
- R7: With pattern_mode high, a claimed read of offset 0 returns 0x55 and raises no rd_req_o. Reads of other offsets, and all writes, behave as in normal mode.
- R8: If bus_ior_n and bus_iow_n are both low, the cycle is ignored: d_drive_o stays low and neither rd_req_o nor wr_valid_o pulses.
- R9: While bus_rst is high, d_drive_o is low at once, the block returns to idle, and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| bus_rst | input | 1 | Active-high reset from the bus, asynchronous |
| bus_ior_n | input | 1 | Read strobe, active low |
| bus_iow_n | input | 1 | Write strobe, active low |
| slot_sel_n | input | 1 | Slot select, active low |
| slot_ioen_n | input | 1 | Slot I/O enable, active low |
| bus_addr | input | 10 | Bus address |
| bus_d | inout | 8 | Tri-state data bus |
| d_drive_o | output | 1 | High while the block drives bus_d (direction control for an external transceiver) |
| pattern_mode | input | 1 | Offset 0 returns the fixed test byte |
| rd_req_o | output | 1 | One-clock read request to the register file |
| rd_off_o | output | 3 | Offset for rd_req_o |
| rd_data_i | input | 8 | Register file read byte, for rd_off_o |
| wr_valid_o | output | 1 | One-clock write beat, no back-pressure |
| wr_off_o | output | 3 | Offset of the write beat |
| wr_data_o | output | 8 | Data of the write beat |

## Verification
A stale active-read flag or a wrong window compare shows at the ports as d_drive_o high on a missed address, on a dropped enable, or after the strobe has risen. The release check samples one nanosecond after the strobe rises, so a release that waits on a clock is caught before the next edge. Faulty edge detection shows up a few cycles after each strobe as missing or doubled rd_req_o or wr_valid_o pulses, or as a write beat carrying the early data byte instead of the final one. A wrong hold register or wrong pattern selection shows up as a wrong byte on bus_d while the strobe is still low.

// File: rtl/isa_slave_pkg.sv
package isa_slave_pkg;
  typedef struct packed {
    logic ior_n;
    logic iow_n;
    logic sel_n;
    logic ioen_n;
  } bus_ctl_t;
  localparam int CTL_W = $bits(bus_ctl_t);
endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/isa_decode.sv
module isa_decode #(
  parameter int ADDR_W = 10,
  parameter int OFF_W = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h2F8
) (
  input  logic              sel_n,
  input  logic              ioen_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  localparam logic [ADDR_W-OFF_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:OFF_W];
  always_comb begin
    hit = !sel_n && !ioen_n && (addr[ADDR_W-1:OFF_W] == BASE_HI);
    off = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/isa_cycle.sv
module isa_cycle #(
  parameter int DATA_W = 8,
  parameter int OFF_W = 3,
  parameter logic [DATA_W-1:0] TEST_BYTE = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ior_s,
  input  logic              iow_s,
  input  logic              ior_raw,
  input  logic              iow_raw,
  input  logic              hit,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] din_s,
  input  logic              pattern_mode,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic              drive_o,
  output logic [DATA_W-1:0] drive_byte_o,
  output logic              wr_valid_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic ior_q, iow_q;
  logic ior_fall, iow_fall, iow_rise;
  logic rd_claim, wr_claim, pat_hit;
  logic rd_act, wr_act;

  always_comb begin
    ior_fall = ior_q && !ior_s;
    iow_fall = iow_q && !iow_s;
    iow_rise = !iow_q && iow_s;
    rd_claim = ior_fall && hit && iow_s;
    wr_claim = iow_fall && hit && ior_s;
    pat_hit  = pattern_mode && (off == '0);
    rd_req_o = rd_claim && !pat_hit;
    rd_off_o = off;
    drive_o  = rd_act && !ior_raw && iow_raw && !rst;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ior_q        <= 1'b1;
      iow_q        <= 1'b1;
      rd_act       <= 1'b0;
      wr_act       <= 1'b0;
      drive_byte_o <= '0;
      wr_off_o     <= '0;
      wr_data_o    <= '0;
      wr_valid_o   <= 1'b0;
    end else begin
      ior_q <= ior_s;
      iow_q <= iow_s;
      if (rd_claim) begin
        rd_act       <= 1'b1;
        drive_byte_o <= pat_hit ? TEST_BYTE : rd_data_i;
      end else if (ior_s || !iow_s) begin
        rd_act <= 1'b0;
      end
      if (wr_claim) begin
        wr_act   <= 1'b1;
        wr_off_o <= off;
      end else if (!ior_s || iow_rise) begin
        wr_act <= 1'b0;
      end
      if (wr_act && !iow_s) wr_data_o <= din_s;
      wr_valid_o <= wr_act && iow_rise && ior_s;
    end
  end
endmodule

// File: rtl/isa_slave_if.sv
module isa_slave_if #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int REG_CNT = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h2F8,
  parameter logic [DATA_W-1:0] TEST_BYTE = 8'h55,
  localparam int OFF_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic              bus_ior_n,
  input  logic              bus_iow_n,
  input  logic              slot_sel_n,
  input  logic              slot_ioen_n,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_d,
  output logic              d_drive_o,
  input  logic              pattern_mode,
  output logic              rd_req_o,
  output logic [OFF_W-1:0]  rd_off_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import isa_slave_pkg::*;
  localparam int PAY_W = ADDR_W + DATA_W;

  bus_ctl_t           ctl_raw, ctl_s;
  logic [PAY_W-1:0]   pay_s;
  logic [ADDR_W-1:0]  addr_s;
  logic [DATA_W-1:0]  din_s;
  logic               hit;
  logic [OFF_W-1:0]   off;
  logic [DATA_W-1:0]  drive_byte;

  always_comb begin
    ctl_raw.ior_n  = bus_ior_n;
    ctl_raw.iow_n  = bus_iow_n;
    ctl_raw.sel_n  = slot_sel_n;
    ctl_raw.ioen_n = slot_ioen_n;
    addr_s = pay_s[PAY_W-1:DATA_W];
    din_s  = pay_s[DATA_W-1:0];
  end

  isa_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk(clk), .rst(bus_rst), .d(ctl_raw), .q(ctl_s)
  );

  isa_sync #(.W(PAY_W), .RST_VAL('0)) u_pay_sync (
    .clk(clk), .rst(bus_rst), .d({bus_addr, bus_d}), .q(pay_s)
  );

  isa_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .sel_n(ctl_s.sel_n), .ioen_n(ctl_s.ioen_n), .addr(addr_s), .hit(hit), .off(off)
  );

  isa_cycle #(.DATA_W(DATA_W), .OFF_W(OFF_W), .TEST_BYTE(TEST_BYTE)) u_cycle (
    .clk(clk), .rst(bus_rst),
    .ior_s(ctl_s.ior_n), .iow_s(ctl_s.iow_n),
    .ior_raw(bus_ior_n), .iow_raw(bus_iow_n),
    .hit(hit), .off(off), .din_s(din_s),
    .pattern_mode(pattern_mode), .rd_data_i(rd_data_i),
    .rd_req_o(rd_req_o), .rd_off_o(rd_off_o),
    .drive_o(d_drive_o), .drive_byte_o(drive_byte),
    .wr_valid_o(wr_valid_o), .wr_off_o(wr_off_o), .wr_data_o(wr_data_o)
  );

  assign bus_d = d_drive_o ? drive_byte : {DATA_W{1'bz}};
endmodule

// File: rtl/isa_slave_if_chk.sv
module isa_slave_if_chk (
  input logic clk,
  input logic bus_rst,
  input logic bus_ior_n,
  input logic bus_iow_n,
  input logic d_drive_o,
  input logic rd_req_o,
  input logic wr_valid_o
);
  always_comb begin
    if (bus_rst) p_no_drive_in_reset_r9: assert (!d_drive_o);
  end

  p_drive_needs_read_r4: assert property (@(posedge clk) disable iff (bus_rst)
    d_drive_o |-> !bus_ior_n);

  p_no_drive_both_r8: assert property (@(posedge clk) disable iff (bus_rst)
    (!bus_ior_n && !bus_iow_n) |-> !d_drive_o);

  p_rd_pulse_once_r5: assert property (@(posedge clk) disable iff (bus_rst)
    rd_req_o |=> !rd_req_o);

  p_wr_pulse_once_r6: assert property (@(posedge clk) disable iff (bus_rst)
    wr_valid_o |=> !wr_valid_o);

  p_wr_after_strobe_r6: assert property (@(posedge clk) disable iff (bus_rst)
    wr_valid_o |-> bus_iow_n);
endmodule

bind isa_slave_if isa_slave_if_chk u_chk (
  .clk(clk), .bus_rst(bus_rst), .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
  .d_drive_o(d_drive_o), .rd_req_o(rd_req_o), .wr_valid_o(wr_valid_o)
);

// File: tb/isa_slave_if_tb.sv
module isa_slave_if_tb;
  logic clk = 1'b0;
  logic bus_rst, ior_n, iow_n, sel_n, ioen_n, pattern;
  logic [9:0] addr;
  logic tb_oe;
  logic [7:0] tb_dq;
  wire  [7:0] bus_d;
  logic d_drive, rd_req, wr_valid;
  logic [2:0] rd_off, wr_off;
  logic [7:0] rd_data, wr_data;

  int total = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [2:0] wr_off_last;
  logic [7:0] wr_dat_last;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign bus_d = tb_oe ? tb_dq : 8'hzz;
  assign rd_data = 8'hA0 + {5'b0, rd_off};

  isa_slave_if u_dut (
    .clk(clk), .bus_rst(bus_rst), .bus_ior_n(ior_n), .bus_iow_n(iow_n),
    .slot_sel_n(sel_n), .slot_ioen_n(ioen_n), .bus_addr(addr), .bus_d(bus_d),
    .d_drive_o(d_drive), .pattern_mode(pattern), .rd_req_o(rd_req),
    .rd_off_o(rd_off), .rd_data_i(rd_data), .wr_valid_o(wr_valid),
    .wr_off_o(wr_off), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (rd_req) rd_cnt <= rd_cnt + 1;
    if (wr_valid) begin
      wr_cnt <= wr_cnt + 1;
      wr_off_last <= wr_off;
      wr_dat_last <= wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // [31] write, [30:21] addr, [20] sel_n, [19] ioen_n, [18] pattern,
  // [17:10] write data, [9] expected hit, [8:1] expected read byte
  localparam logic [31:0] VEC [14] = '{
    {1'b0, 10'h2F8, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hA0, 1'b0},
    {1'b0, 10'h2FB, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hA3, 1'b0},
    {1'b0, 10'h2FF, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hA7, 1'b0},
    {1'b0, 10'h2F8, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h55, 1'b0},
    {1'b0, 10'h2F9, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'hA1, 1'b0},
    {1'b0, 10'h3F8, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
    {1'b0, 10'h2F0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
    {1'b0, 10'h2F8, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
    {1'b0, 10'h2F8, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
    {1'b1, 10'h2FA, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 8'h00, 1'b0},
    {1'b1, 10'h2FF, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b1, 8'h00, 1'b0},
    {1'b1, 10'h0F8, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 8'h00, 1'b0},
    {1'b1, 10'h2F8, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0, 8'h00, 1'b0},
    {1'b1, 10'h2F8, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bus_rst = 1'b1; ior_n = 1'b1; iow_n = 1'b1; sel_n = 1'b1; ioen_n = 1'b1;
    pattern = 1'b0; addr = '0; tb_oe = 1'b0; tb_dq = '0;
    repeat (3) @(negedge clk);
    check("R9 reset drive", {31'b0, d_drive}, 0);
    bus_rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 idle after reset rd_req", {31'b0, rd_req}, 0);
    check("R9 idle after reset wr_valid", {31'b0, wr_valid}, 0);

    for (int i = 0; i < 14; i++) begin
      logic [31:0] v;
      logic hit, pulse;
      int rc, wc;
      v = VEC[i];
      hit = v[9];
      addr = v[30:21]; sel_n = v[20]; ioen_n = v[19]; pattern = v[18];
      rc = rd_cnt; wc = wr_cnt;
      if (!v[31]) begin
        pulse = hit && !(v[18] && v[23:21] == 3'd0);
        @(negedge clk); ior_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 R2 R3 drive on read", {31'b0, d_drive}, {31'b0, hit});
        if (hit) check("R3 R7 read byte", {24'b0, bus_d}, {24'b0, v[8:1]});
        ior_n = 1'b1;
        #1;
        check("R4 release on strobe high", {31'b0, d_drive}, 0);
        repeat (4) @(negedge clk);
        check("R5 R7 read pulse count", rc + (pulse ? 1 : 0), rd_cnt);
      end else begin
        tb_oe = 1'b1; tb_dq = ~v[17:10];
        @(negedge clk); iow_n = 1'b0;
        repeat (4) @(negedge clk);
        tb_dq = v[17:10];
        repeat (4) @(negedge clk);
        iow_n = 1'b1;
        repeat (3) @(negedge clk);
        tb_oe = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 no drive on write", {31'b0, d_drive}, 0);
        check("R1 R2 R6 write beat count", wr_cnt, wc + (hit ? 1 : 0));
        if (hit) begin
          check("R6 write offset", {29'b0, wr_off_last}, {29'b0, v[23:21]});
          check("R6 R7 write data at rise", {24'b0, wr_dat_last}, {24'b0, v[17:10]});
        end
      end
    end

    // R8: both strobes low together
    begin
      int rc, wc;
      addr = 10'h2F9; sel_n = 1'b0; ioen_n = 1'b0; pattern = 1'b0;
      rc = rd_cnt; wc = wr_cnt;
      @(negedge clk); ior_n = 1'b0; iow_n = 1'b0;
      repeat (6) @(negedge clk);
      check("R8 no drive with both strobes", {31'b0, d_drive}, 0);
      ior_n = 1'b1; iow_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R8 no read pulse", rd_cnt, rc);
      check("R8 no write beat", wr_cnt, wc);
    end

    // R9: reset during an active read
    begin
      int rc;
      addr = 10'h2FC;
      @(negedge clk); ior_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R3 drive before reset", {31'b0, d_drive}, 1);
      rc = rd_cnt;
      bus_rst = 1'b1;
      #1;
      check("R9 release on reset", {31'b0, d_drive}, 0);
      @(negedge clk); ior_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_rst = 1'b0;
      repeat (5) @(negedge clk);
      check("R9 idle after reset", {31'b0, d_drive}, 0);
      check("R9 no pulse from reset", rd_cnt, rc);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule